// File: doc/BRIEF.md
# Single-Cycle CPU Control Decoder

A purely combinational control unit for a 32-bit single-cycle RISC datapath. Each cycle it reads the 6-bit opcode of the current instruction, a flag that is high when the first register operand is zero, and an interrupt request. From these it drives every select and strobe of the datapath: next-PC source, the address source of the second register read port, the A and B operand sources, the ALU function, the write-back source, the data-memory write strobe, the register-file write enable and the choice of destination register.

Instruction fields are fixed: destination/store-data register in bits 25:21, first source in bits 20:16, second source in bits 15:11, and a signed 16-bit literal in bits 15:0. The ALU, both memories, the register file and the PC adders live outside this block.

When an interrupt is pending, or the opcode is not assigned, the decoder turns the instruction into a forced call. It selects an exception vector, writes PC+4 into the reserved exception-return register, and holds the memory write strobe low.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: For opcodes 10xxxx with no exception, the outputs are b_sel=0 (second register operand), ra2_sel=0, wd_sel=1 (ALU), rf_we=1, mem_wr=0, pc_sel=0 (PC+4) and alu_fn=opcode[3:0].
- R2: For opcodes 11xxxx with no exception, the outputs match R1 except that b_sel=1 (sign-extended literal).
- R3: ALU function codes (opcode[3:0]) are ADD=0, SUB=1, MUL=2, DIV=3, CMPEQ=4, CMPLT=5, CMPLE=6, AND=8, OR=9, XOR=10, SHL=12, SHR=13 and SRA=14. Codes 7, 11 and 15 are illegal in both operate forms. Codes 2 and 3 are illegal when HAS_MULDIV is 0.
- R4: LD (011000) gives alu_fn=0, b_sel=1, wd_sel=2 (memory), rf_we=1, mem_wr=0 and pc_sel=0.
- R5: ST (011001) gives ra2_sel=1, b_sel=1, alu_fn=0, mem_wr=1, rf_we=0 and pc_sel=0.
- R6: JMP (011011) gives pc_sel=2 (register Ra), wd_sel=0 (PC+4) and rf_we=1.
- R7: BEQ (011101) gives pc_sel=1 (branch target) when ra_zero=1, otherwise 0. BNE (011110) does the reverse. Both give wd_sel=0 and rf_we=1.
- R8: LDR (011111) gives a_sel=1 (branch-target adder), alu_fn=7 (pass A), wd_sel=2, rf_we=1 and pc_sel=0.
- R9: Any other opcode with irq=0 gives pc_sel=3 (illegal-op vector), wa_sel=1 (exception register), wd_sel=0 and rf_we=1.
- R10: With irq=1, any opcode gives pc_sel=4 (interrupt vector), wa_sel=1, wd_sel=0 and rf_we=1.
- R11: During an exception (R9 or R10), mem_wr=0 and every output not named in R9/R10 is 0. Outside an exception, wa_sel=0. In R1–R8, any output not named is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| ra_zero | input | 1 | High when register Ra reads zero |
| irq | input | 1 | Pending asynchronous interrupt |
| pc_sel | output | 3 | Next PC: 0 PC+4, 1 branch, 2 Ra, 3 illegal vector, 4 interrupt vector |
| ra2_sel | output | 1 | Second read address: 0 Rb, 1 Rc |
| a_sel | output | 1 | A operand: 0 register, 1 branch target |
| b_sel | output | 1 | B operand: 0 register, 1 literal |
| alu_fn | output | 4 | ALU function code |
| wd_sel | output | 2 | Write-back: 0 PC+4, 1 ALU, 2 memory |
| mem_wr | output | 1 | Data-memory write strobe |
| rf_we | output | 1 | Register-file write enable |
| wa_sel | output | 1 | Write address: 0 Rc, 1 exception register |

## Verification
On every input change, the assertions check three exception properties: mem_wr stays low and the return-address write goes to the exception register during an exception, and an interrupt always wins the PC select. They also check that ST never writes the register file, that the branch direction follows ra_zero, and that the exception register is never chosen outside an exception. Only the bench's exhaustive sweep over opcode, zero flag and interrupt can show the exact alu_fn and operand selects for each class. The random mix adds coverage of the same input space, and the full legal/illegal split of the function codes is confirmed only by that sweep.

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder #(
  parameter bit HAS_MULDIV = 1'b1
) (
  input  logic [5:0] opcode,
  input  logic       ra_zero,
  input  logic       irq,
  output logic [2:0] pc_sel,
  output logic       ra2_sel,
  output logic       a_sel,
  output logic       b_sel,
  output logic [3:0] alu_fn,
  output logic [1:0] wd_sel,
  output logic       mem_wr,
  output logic       rf_we,
  output logic       wa_sel
);
  localparam logic [5:0] OP_LD = 6'b011000, OP_ST = 6'b011001, OP_JMP = 6'b011011;
  localparam logic [5:0] OP_BEQ = 6'b011101, OP_BNE = 6'b011110, OP_LDR = 6'b011111;
  localparam logic [2:0] PC_NEXT = 3'd0, PC_BR = 3'd1, PC_REG = 3'd2, PC_ILL = 3'd3, PC_IRQ = 3'd4;
  localparam logic [1:0] WD_PC4 = 2'd0, WD_ALU = 2'd1, WD_MEM = 2'd2;
  localparam logic [3:0] FN_ADD = 4'd0, FN_PASSA = 4'd7;

  logic fn_ok, legal;

  always_comb begin
    case (opcode[3:0])
      4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14: fn_ok = 1'b1;
      4'd2, 4'd3: fn_ok = HAS_MULDIV;
      default: fn_ok = 1'b0;
    endcase
  end

  always_comb begin
    pc_sel  = PC_NEXT;
    ra2_sel = 1'b0;
    a_sel   = 1'b0;
    b_sel   = 1'b0;
    alu_fn  = FN_ADD;
    wd_sel  = WD_PC4;
    mem_wr  = 1'b0;
    rf_we   = 1'b0;
    wa_sel  = 1'b0;
    legal   = 1'b1;
    if (opcode[5]) begin
      legal  = fn_ok;
      alu_fn = opcode[3:0];
      b_sel  = opcode[4];
      wd_sel = WD_ALU;
      rf_we  = 1'b1;
    end else begin
      case (opcode)
        OP_LD:  begin b_sel = 1'b1; wd_sel = WD_MEM; rf_we = 1'b1; end
        OP_ST:  begin b_sel = 1'b1; ra2_sel = 1'b1; mem_wr = 1'b1; end
        OP_JMP: begin pc_sel = PC_REG; rf_we = 1'b1; end
        OP_BEQ: begin pc_sel = ra_zero ? PC_BR : PC_NEXT; rf_we = 1'b1; end
        OP_BNE: begin pc_sel = ra_zero ? PC_NEXT : PC_BR; rf_we = 1'b1; end
        OP_LDR: begin a_sel = 1'b1; alu_fn = FN_PASSA; wd_sel = WD_MEM; rf_we = 1'b1; end
        default: legal = 1'b0;
      endcase
    end
    if (irq || !legal) begin
      pc_sel  = irq ? PC_IRQ : PC_ILL;
      ra2_sel = 1'b0;
      a_sel   = 1'b0;
      b_sel   = 1'b0;
      alu_fn  = FN_ADD;
      wd_sel  = WD_PC4;
      mem_wr  = 1'b0;
      rf_we   = 1'b1;
      wa_sel  = 1'b1;
    end
  end
endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk (
  input logic [5:0] opcode,
  input logic       ra_zero,
  input logic       irq,
  input logic [2:0] pc_sel,
  input logic       ra2_sel,
  input logic [1:0] wd_sel,
  input logic       mem_wr,
  input logic       rf_we,
  input logic       wa_sel
);
  logic exc;
  assign exc = (pc_sel == 3'd3) || (pc_sel == 3'd4);

  always_comb begin
    if (!$isunknown({opcode, ra_zero, irq})) begin
      AST_IRQ_WINS: assert (!irq || pc_sel == 3'd4); // R10
      AST_EXC_NO_MEMWR: assert (!exc || !mem_wr); // R11
      AST_EXC_SAVES_RET: assert (!exc || (rf_we && wa_sel && wd_sel == 2'd0)); // R9
      AST_XP_ONLY_IN_EXC: assert (exc || !wa_sel); // R11
      AST_ST_NO_REGWR: assert (irq || opcode != 6'b011001 || (!rf_we && mem_wr && ra2_sel)); // R5
      AST_BEQ_DIR: assert (irq || opcode != 6'b011101 || pc_sel == (ra_zero ? 3'd1 : 3'd0)); // R7
      AST_BNE_DIR: assert (irq || opcode != 6'b011110 || pc_sel == (ra_zero ? 3'd0 : 3'd1)); // R7
    end
  end
endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk u_chk (
  .opcode(opcode), .ra_zero(ra_zero), .irq(irq), .pc_sel(pc_sel), .ra2_sel(ra2_sel),
  .wd_sel(wd_sel), .mem_wr(mem_wr), .rf_we(rf_we), .wa_sel(wa_sel)
);

// File: tb/sc_ctrl_decoder_test.sv
module sc_ctrl_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] opcode = 6'd0;
  logic ra_zero = 1'b0, irq = 1'b0;
  logic [2:0] pc_sel;
  logic ra2_sel, a_sel, b_sel, mem_wr, rf_we, wa_sel;
  logic [3:0] alu_fn;
  logic [1:0] wd_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  sc_ctrl_decoder #(.HAS_MULDIV(1'b1)) uut (
    .opcode(opcode), .ra_zero(ra_zero), .irq(irq), .pc_sel(pc_sel), .ra2_sel(ra2_sel),
    .a_sel(a_sel), .b_sel(b_sel), .alu_fn(alu_fn), .wd_sel(wd_sel), .mem_wr(mem_wr),
    .rf_we(rf_we), .wa_sel(wa_sel)
  );

  // packed order: pc_sel, ra2_sel, a_sel, b_sel, alu_fn, wd_sel, mem_wr, rf_we, wa_sel
  function automatic logic [14:0] expect_of(input logic [5:0] op, input logic z, input logic i);
    logic [3:0] f;
    f = op[3:0];
    if (i) return {3'd4, 3'b000, 4'd0, 2'd0, 3'b011};                          // R10
    if (op[5:4] == 2'b10 && f != 7 && f != 11 && f != 15)
      return {3'd0, 3'b000, f, 2'd1, 3'b010};                                  // R1 R3
    if (op[5:4] == 2'b11 && f != 7 && f != 11 && f != 15)
      return {3'd0, 3'b001, f, 2'd1, 3'b010};                                  // R2 R3
    if (op == 6'o30) return {3'd0, 3'b001, 4'd0, 2'd2, 3'b010};                // R4
    if (op == 6'o31) return {3'd0, 3'b101, 4'd0, 2'd0, 3'b100};                // R5
    if (op == 6'o33) return {3'd2, 3'b000, 4'd0, 2'd0, 3'b010};                // R6
    if (op == 6'o35) return {z ? 3'd1 : 3'd0, 3'b000, 4'd0, 2'd0, 3'b010};     // R7
    if (op == 6'o36) return {z ? 3'd0 : 3'd1, 3'b000, 4'd0, 2'd0, 3'b010};     // R7
    if (op == 6'o37) return {3'd0, 3'b010, 4'd7, 2'd2, 3'b010};                // R8
    return {3'd3, 3'b000, 4'd0, 2'd0, 3'b011};                                 // R9 R11
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic i);
    if (i) return "R10";
    if (op[5] && (op[3:0] == 7 || op[3:0] == 11 || op[3:0] == 15)) return "R3/R9";
    if (op[5:4] == 2'b10) return "R1";
    if (op[5:4] == 2'b11) return "R2";
    case (op)
      6'o30: return "R4";
      6'o31: return "R5";
      6'o33: return "R6";
      6'o35, 6'o36: return "R7";
      6'o37: return "R8";
      default: return "R9/R11";
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic z, input logic i);
    logic [14:0] got, exp;
    @(negedge clk);
    opcode = op; ra_zero = z; irq = i;
    #2;
    got = {pc_sel, ra2_sel, a_sel, b_sel, alu_fn, wd_sel, mem_wr, rf_we, wa_sel};
    exp = expect_of(op, z, i);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%b z=%b irq=%b got=%h exp=%h", req_of(op, i), op, z, i, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd5150);
    apply(6'b100000, 1'b0, 1'b0);        // reset-like idle: ADD register form, R1
    apply(6'b111111, 1'b1, 1'b0);        // R3 illegal literal code 15
    apply(6'b011001, 1'b0, 1'b1);        // R10 interrupt masks store, R11
    apply(6'b000000, 1'b1, 1'b0);        // R9
    for (int op = 0; op < 64; op++)
      for (int k = 0; k < 4; k++)
        apply(op[5:0], k[0], k[1]);
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom;
      apply(r[5:0], r[6], r[9:7] == 3'd0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule